// File: doc/BRIEF.md
# Synchronous Burst SRAM Read/Write Datapath

This block is the storage and data side of a synchronous burst SRAM with a small, parameterised depth. Each rising clock edge samples an address, supplied every cycle by an external burst sequencer, together with a chip select, write controls, per-lane selects and write data. The block stores the data in byte lanes of nine bits, eight data bits and one parity bit, kept exactly as written. A write covers either a chosen set of lanes or the whole word. Read data comes back with one of two latencies. A static mode input picks between them: it either skips the output register or passes through it.

Deselect cycles go through the same pipeline stages as reads. When the chip is deselected, the bus is therefore released with read latency and not at once: a deselect that follows a read in pipelined mode leaves the read's data on the bus for one more full cycle. An output enable gates the bus with no clock. A sleep input blocks all activity and releases the bus, and the stored words are kept.

Top module: `ssram_datapath`

## Requirements
- R1: Flow-through mode (`pipe_mode`=0). A read sampled at clock edge k puts the word on `dout` with `dout_valid`=1 right after edge k, so the data can be captured at edge k+1. This is two clocks counting the address edge.
- R2: Pipelined mode (`pipe_mode`=1). A read sampled at edge k has `dout_valid`=0 after edge k and shows the word after edge k+1. This is three clocks counting the address edge.
- R3: Reads on consecutive edges give one new word per clock, in the order they were issued, in either mode.
- R4: A lane write happens when `chip_sel`=1, `wr_all`=0, `wr_bytes`=1. Lane i is `din[9*i+8:9*i]` and is selected by `lane_sel[i]`. Only the selected lanes change; the other lanes keep their contents.
- R5: With `chip_sel`=1 and `wr_all`=1, every lane is written, whatever `wr_bytes` and `lane_sel` hold.
- R6: With `chip_sel`=1, `wr_all`=0 and `wr_bytes`=0, the cycle is a read. With `wr_bytes`=1 and `lane_sel` all zero, nothing is written and the bus is not driven.
- R7: A deselect (`chip_sel`=0) releases the bus with the same latency as a read. In pipelined mode the bus stays driven through the cycle after the deselect edge and is off after the following edge.
- R8: A write cycle never drives the bus in the slot where a read would have.
- R9: `out_en`=0 forces `dout_valid`=0 and `dout`=0 at once, with no clock edge needed. Raising it again restores the word held in the pipeline.
- R10: `sleep`=1 forces `dout_valid`=0 at once, ignores all other inputs (no write takes place), empties the read pipeline and keeps the stored words. The first edge after release is handled normally.
- R11: Reset is synchronous and active high. It empties the read pipeline so that `dout_valid`=0 and `dout`=0 after the reset edge, and it leaves the stored words unchanged.
- R12: A read on the edge right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| sleep | input | 1 | Low-power hold; ignores inputs, releases bus, keeps data |
| out_en | input | 1 | Asynchronous output enable, active high |
| chip_sel | input | 1 | Chip select; 0 = deselect cycle |
| wr_all | input | 1 | Whole-word write, overrides lane writes |
| wr_bytes | input | 1 | Lane write enable, used with `lane_sel` |
| lane_sel | input | LANES | Per-lane write select |
| addr | input | AW | Word address from the burst sequencer |
| din | input | LANES*9 | Write data, nine bits per lane |
| dout | output | LANES*9 | Read data, zero while not driven |
| dout_valid | output | 1 | Bus drive / data valid; 0 means high impedance at the pad |

## Verification
The bench targets the latency edges. A flow-through design that added the output register would return the word one clock late, and a pipelined design that skipped it would return it one clock early. A design that turned the bus off directly from the deselect would cut off the last beat of a pipelined burst. The bench also covers lane masking with mixed selects, a whole-word write that has every lane select cleared, and a lane write with no select. A design that got either of these wrong would corrupt or leave lanes that the bench reads back. Finally, it issues a write during sleep and a read just after sleep or reset. A design that leaked stale pipeline data, or honoured inputs while asleep, would show a wrong word or drive the bus too early.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  localparam int LANE_BITS = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Whole-word write wins over lane write; neither asserted means read.
  function automatic op_e decode_op(input logic sel, input logic all, input logic bytes);
    if (!sel)               return OP_IDLE;
    else if (all || bytes)  return OP_WRITE;
    else                    return OP_READ;
  endfunction

endpackage

// File: rtl/ssram_cmd.sv
module ssram_cmd
  import ssram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             chip_sel,
  input  logic             wr_all,
  input  logic             wr_bytes,
  input  logic [LANES-1:0] lane_sel,
  output logic [LANES-1:0] lane_we,
  output logic             rd_issue
);

  op_e op;

  always_comb begin
    op = decode_op(chip_sel, wr_all, wr_bytes);
    if (rst || sleep) op = OP_IDLE;
    lane_we = '0;
    if (op == OP_WRITE) lane_we = wr_all ? {LANES{1'b1}} : lane_sel;
  end

  // First read stage: deselects and writes load zero, like a read loads one.
  always_ff @(posedge clk) begin
    if (rst || sleep) rd_issue <= 1'b0;
    else              rd_issue <= (op == OP_READ);
  end

  assert_sleep_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (lane_we == '0));

  assert_whole_word_R5: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && wr_all && !sleep) |-> (&lane_we));

  assert_read_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (chip_sel && !wr_all && !wr_bytes) |-> (lane_we == '0));

endmodule

// File: rtl/ssram_lane.sv
module ssram_lane #(
  parameter int AW    = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  // Single-port, registered read: maps onto an inferred block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/ssram_out.sv
module ssram_out #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sleep,
  input  logic         pipe_mode,
  input  logic         out_en,
  input  logic         rd_issue,
  input  logic [W-1:0] rd_word,
  output logic [W-1:0] dout,
  output logic         dout_valid
);

  logic         pipe_drive;
  logic [W-1:0] pipe_word;
  logic         drive_sel;
  logic [W-1:0] word_sel;

  always_ff @(posedge clk) begin
    if (rst || sleep) pipe_drive <= 1'b0;
    else              pipe_drive <= rd_issue;
  end

  always_ff @(posedge clk) pipe_word <= rd_word;

  always_comb begin
    drive_sel  = pipe_mode ? pipe_drive : rd_issue;
    word_sel   = pipe_mode ? pipe_word  : rd_word;
    dout_valid = drive_sel && out_en && !sleep;
    dout       = dout_valid ? word_sel : '0;
  end

  assert_oe_gates_bus_R9: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> (!dout_valid && dout == '0));

  assert_sleep_releases_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_valid);

endmodule

// File: rtl/ssram_datapath.sv
module ssram_datapath
  import ssram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pipe_mode,
  input  logic                       sleep,
  input  logic                       out_en,
  input  logic                       chip_sel,
  input  logic                       wr_all,
  input  logic                       wr_bytes,
  input  logic [LANES-1:0]           lane_sel,
  input  logic [AW-1:0]              addr,
  input  logic [LANES*LANE_BITS-1:0] din,
  output logic [LANES*LANE_BITS-1:0] dout,
  output logic                       dout_valid
);

  localparam int W = LANES * LANE_BITS;

  logic [LANES-1:0] lane_we;
  logic             rd_issue;
  logic [W-1:0]     rd_word;

  ssram_cmd #(.LANES(LANES)) i_cmd (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .chip_sel (chip_sel),
    .wr_all   (wr_all),
    .wr_bytes (wr_bytes),
    .lane_sel (lane_sel),
    .lane_we  (lane_we),
    .rd_issue (rd_issue)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ssram_lane #(.AW(AW), .WIDTH(LANE_BITS)) i_lane (
      .clk   (clk),
      .we    (lane_we[g]),
      .addr  (addr),
      .wdata (din[g*LANE_BITS +: LANE_BITS]),
      .rdata (rd_word[g*LANE_BITS +: LANE_BITS])
    );
  end

  ssram_out #(.W(W)) i_out (
    .clk        (clk),
    .rst        (rst),
    .sleep      (sleep),
    .pipe_mode  (pipe_mode),
    .out_en     (out_en),
    .rd_issue   (rd_issue),
    .rd_word    (rd_word),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

  logic rd_req;
  assign rd_req = chip_sel && !wr_all && !wr_bytes && !sleep && !rst;

  assert_flow_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && out_en && !sleep && $past(rd_req)) |-> dout_valid);

  assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && out_en && !sleep && !$past(sleep) && !$past(rst) && $past(rd_req, 2))
      |-> dout_valid);

  assert_deselect_delay_R7: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && $past(!chip_sel, 2)) |-> !dout_valid);

endmodule

// File: tb/test_ssram_datapath.sv
`timescale 1ns/1ps
module test_ssram_datapath;

  localparam int AW = 4;
  localparam int LANES = 2;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_mode = 1'b0, sleep = 1'b0, out_en = 1'b1;
  logic chip_sel = 1'b0, wr_all = 1'b0, wr_bytes = 1'b0;
  logic [LANES-1:0] lane_sel = '0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_valid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ssram_datapath #(.AW(AW), .LANES(LANES)) i_ssram_datapath (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .sleep(sleep), .out_en(out_en),
    .chip_sel(chip_sel), .wr_all(wr_all), .wr_bytes(wr_bytes), .lane_sel(lane_sel),
    .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  typedef struct packed {
    logic        sel;
    logic        all;
    logic        bytes;
    logic [1:0]  lanes;
    logic [3:0]  a;
    logic [17:0] d;
    logic        ev;
    logic [17:0] eq;
    logic [3:0]  req;
  } vec_t;

  // Flow-through mode; each row's result is sampled after its own edge.
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 2'b00, 4'd1,  18'h2A5A5, 1'b0, 18'h00000, 4'd8},  // R8 write, no drive
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd1,  18'h00000, 1'b1, 18'h2A5A5, 4'd12}, // R12 read after write
    '{1'b1, 1'b0, 1'b1, 2'b01, 4'd1,  18'h00123, 1'b0, 18'h00000, 4'd4},  // R4 lane 0 only
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd1,  18'h00000, 1'b1, 18'h2A523, 4'd4},
    '{1'b1, 1'b0, 1'b1, 2'b10, 4'd1,  18'h3FE00, 1'b0, 18'h00000, 4'd4},  // R4 lane 1 only
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd1,  18'h00000, 1'b1, 18'h3FF23, 4'd4},
    '{1'b1, 1'b1, 1'b1, 2'b00, 4'd2,  18'h15555, 1'b0, 18'h00000, 4'd5},  // R5 whole word, no selects
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd2,  18'h00000, 1'b1, 18'h15555, 4'd5},
    '{1'b1, 1'b0, 1'b1, 2'b00, 4'd2,  18'h00000, 1'b0, 18'h00000, 4'd6},  // R6 lane write, no lanes
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd2,  18'h00000, 1'b1, 18'h15555, 4'd6},
    '{1'b0, 1'b0, 1'b0, 2'b00, 4'd2,  18'h00000, 1'b0, 18'h00000, 4'd7},  // R7 flow deselect
    '{1'b1, 1'b1, 1'b0, 2'b00, 4'd15, 18'h00001, 1'b0, 18'h00000, 4'd8},
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd15, 18'h00000, 1'b1, 18'h00001, 4'd1},  // R1 flow latency
    '{1'b1, 1'b0, 1'b0, 2'b00, 4'd1,  18'h00000, 1'b1, 18'h3FF23, 4'd3}   // R3 back-to-back
  };

  task automatic check(input string tag, input logic [W-1:0] eq, input logic ev);
    checks++;
    if (dout_valid !== ev || dout !== eq) begin
      errors++;
      $display("FAIL %s: dout=%h dout_valid=%b expected dout=%h dout_valid=%b",
               tag, dout, dout_valid, eq, ev);
    end
  endtask

  task automatic drive(input logic s, input logic a, input logic b,
                       input logic [1:0] l, input logic [AW-1:0] ad, input logic [W-1:0] d);
    chip_sel = s; wr_all = a; wr_bytes = b; lane_sel = l; addr = ad; din = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    tick(); tick();
    check("R11 reset state", '0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].sel, TBL[i].all, TBL[i].bytes, TBL[i].lanes, TBL[i].a, TBL[i].d);
      tick();
      check($sformatf("R%0d table row %0d", TBL[i].req, i), TBL[i].eq, TBL[i].ev);
    end

    // Pipelined latency and deselect delay
    pipe_mode = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 2'b00, 4'd0, '0);
    tick(); tick();
    check("R7 idle pipelined", '0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd2, '0);
    tick();
    check("R2 not yet after first edge", '0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd1, '0);
    tick();
    check("R2 word after second edge", 18'h15555, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 2'b00, 4'd0, '0);
    tick();
    check("R3 R7 next beat held past deselect edge", 18'h3FF23, 1'b1);
    tick();
    check("R7 released after following edge", '0, 1'b0);

    // Asynchronous output enable
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd2, '0);
    tick(); tick();
    check("R2 steady read", 18'h15555, 1'b1);
    out_en = 1'b0; #1;
    check("R9 oe low without clock", '0, 1'b0);
    out_en = 1'b1; #1;
    check("R9 oe restored", 18'h15555, 1'b1);

    // Sleep: write attempt ignored, pipeline emptied, data kept
    @(negedge clk);
    sleep = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 2'b00, 4'd2, 18'h00000);
    #1;
    check("R10 bus released at once", '0, 1'b0);
    tick(); tick();
    check("R10 bus stays released", '0, 1'b0);
    sleep = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd2, '0);
    tick();
    check("R10 pipeline emptied by sleep", '0, 1'b0);
    tick();
    check("R10 contents kept, write ignored", 18'h15555, 1'b1);

    // Mid-run reset
    rst = 1'b1;
    tick();
    check("R11 reset empties pipeline", '0, 1'b0);
    rst = 1'b0;
    tick(); tick();
    check("R11 memory kept across reset", 18'h15555, 1'b1);

    finish_run();
  end

endmodule